// File: doc/BRIEF.md
# Retriggerable Clearable Digital One-Shot

This block is a clocked pulse stretcher that stands in for a retriggerable monostable. It watches two active-low trigger pins, two active-high trigger pins and an active-low clear. When these inputs together move from "not armed" to "armed", the block starts a pulse. The pulse lasts for a number of clock cycles taken from a length input. The output pair `q` / `q_n` is complementary and registered. A fresh arming edge while a pulse is running reloads the full length, so a steady stream of triggers holds the pulse for as long as the stream lasts.

Pulling clear low stops any running pulse on the next clock edge and keeps the block from arming. Releasing clear while the other pins already satisfy the arming rule counts as a trigger. All inputs are assumed to be synchronous to `clk`. Edge detection compares each pin with a registered copy of its value from the previous cycle.

Top module: `osh_pulse_gen`

## Requirements
- R1: With `clr_n`=1, `rise1`=`rise2`=1 and `fall2_n`=1, a 1-to-0 change on `fall1_n` (or, symmetrically, on `fall2_n` with `fall1_n`=1) starts a pulse.
- R2: With `clr_n`=1, one of `fall1_n`/`fall2_n` low and the other rising pin high, a 0-to-1 change on `rise1` or `rise2` starts a pulse.
- R3: The arming condition is `clr_n & rise1 & rise2 & (~fall1_n | ~fall2_n)`. A trigger is the cycle in which this condition is true after being false in the previous cycle. `q` rises at the clock edge that sees the trigger and stays high for exactly `pulse_len` cycles. `pulse_len` is sampled only at that edge.
- R4: `q_n` is always the inverse of `q`.
- R5: A trigger during a running pulse reloads the full `pulse_len`. `q` does not drop at any point, so the total high time is the cycles elapsed before the retrigger plus the new length.
- R6: `clr_n`=0 at a clock edge forces `q`=0 at that edge, ending any pulse.
- R7: While `clr_n`=0, no input change starts a pulse.
- R8: A 0-to-1 change on `clr_n` starts a pulse when the rising pins are high and a falling pin is low. Releasing clear with both falling pins high starts nothing.
- R9: A trigger with `pulse_len`=0 produces no pulse. If a pulse is running, such a trigger ends it at that edge.
- R10: Synchronous `rst`=1 gives `q`=0, `q_n`=1 and an idle timer. No trigger fires in the reset cycle.
- R11: A pin edge that leaves the arming condition true (for example, the second falling pin going low while the first is already low) does not restart the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| fall1_n | input | 1 | trigger pin, acts on its falling edge |
| fall2_n | input | 1 | trigger pin, acts on its falling edge |
| rise1 | input | 1 | trigger pin, acts on its rising edge |
| rise2 | input | 1 | trigger pin, acts on its rising edge |
| clr_n | input | 1 | active-low clear; its release can trigger |
| pulse_len | input | LEN_W | pulse length in clock cycles |
| q | output | 1 | pulse output, high while active |
| q_n | output | 1 | complement of q |

## Verification
Each input pattern set up before a clock edge shows its effect on `q`/`q_n` at that same edge, so the result is due one cycle after the stimulus and is sampled at the following falling edge. The bench drives pins only on falling edges. A behavioural model advances on each rising edge from the same pins, and outputs are compared on every falling edge. Directed phases also count the high cycles of each pulse and check the total against the length worked out from R3, R5, R6 and R9 once the pulse has settled back to idle.

// File: rtl/osh_pkg.sv
package osh_pkg;

  localparam int OSH_LEN_W_DEF = 8;

  // Arming rule: clear released, all rising-type pins high, some falling-type pin low.
  function automatic logic osh_armed(input logic clr_n_i,
                                     input logic [1:0] rise_i,
                                     input logic [1:0] fall_n_i);
    return clr_n_i & (&rise_i) & ~(&fall_n_i);
  endfunction

endpackage

// File: rtl/osh_trigger_detect.sv
module osh_trigger_detect
  import osh_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] fall_n,
  input  logic [1:0] rise,
  input  logic       clr_n,
  output logic       fire
);

  logic [1:0] fall_n_q;
  logic [1:0] rise_q;
  logic       clr_n_q;
  logic       armed_now;
  logic       armed_prev;

  // Pin copies are loaded during reset as well, so no edge is seen on release.
  always_ff @(posedge clk) begin
    fall_n_q <= fall_n;
    rise_q   <= rise;
    clr_n_q  <= clr_n;
  end

  always_comb begin
    armed_now  = osh_armed(clr_n, rise, fall_n);
    armed_prev = osh_armed(clr_n_q, rise_q, fall_n_q);
    fire       = armed_now & ~armed_prev & ~rst;
  end

  // R7: a held clear blocks every trigger
  p_clear_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    !clr_n |-> !fire);

  // R11: no trigger unless the rule was false a cycle ago
  p_needs_edge_r11: assert property (@(posedge clk) disable iff (rst)
    $past(osh_armed(clr_n, rise, fall_n)) |-> !fire);

endmodule

// File: rtl/osh_timer.sv
module osh_timer #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_n,
  input  logic             fire,
  input  logic [LEN_W-1:0] load_len,
  output logic             busy_nxt
);

  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt;
    if (!clr_n)          cnt_nxt = '0;
    else if (fire)       cnt_nxt = load_len;
    else if (cnt != '0)  cnt_nxt = cnt - 1'b1;
    busy_nxt = (cnt_nxt != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nxt;
  end

  // R3: an untouched count steps down by one each cycle
  p_count_down_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) && !fire && clr_n |=> cnt == LEN_W'($past(cnt) - 1'b1));

  // R6: clear empties the timer
  p_clear_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> cnt == '0);

  // R5: a retrigger reloads the full length
  p_reload_r5: assert property (@(posedge clk) disable iff (rst)
    fire && clr_n |=> cnt == $past(load_len));

endmodule

// File: rtl/osh_out_stage.sv
module osh_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic busy_nxt,
  output logic q,
  output logic q_n
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= 1'b0;
      q_n <= 1'b1;
    end else begin
      q   <= busy_nxt;
      q_n <= ~busy_nxt;
    end
  end

  // R4: outputs stay complementary
  p_complement_r4: assert property (@(posedge clk) disable iff (rst)
    q != q_n);

endmodule

// File: rtl/osh_pulse_gen.sv
module osh_pulse_gen
  import osh_pkg::*;
#(
  parameter int LEN_W = OSH_LEN_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fall1_n,
  input  logic             fall2_n,
  input  logic             rise1,
  input  logic             rise2,
  input  logic             clr_n,
  input  logic [LEN_W-1:0] pulse_len,
  output logic             q,
  output logic             q_n
);

  logic fire;
  logic busy_nxt;

  osh_trigger_detect u_det (
    .clk    (clk),
    .rst    (rst),
    .fall_n ({fall2_n, fall1_n}),
    .rise   ({rise2, rise1}),
    .clr_n  (clr_n),
    .fire   (fire)
  );

  osh_timer #(.LEN_W(LEN_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .clr_n    (clr_n),
    .fire     (fire),
    .load_len (pulse_len),
    .busy_nxt (busy_nxt)
  );

  osh_out_stage u_out (
    .clk      (clk),
    .rst      (rst),
    .busy_nxt (busy_nxt),
    .q        (q),
    .q_n      (q_n)
  );

  // R3: a trigger with a non-zero length raises q at that edge
  p_fire_starts_r3: assert property (@(posedge clk) disable iff (rst)
    fire && (pulse_len != '0) |=> q);

  // R9: a zero-length trigger leaves q low
  p_zero_len_r9: assert property (@(posedge clk) disable iff (rst)
    fire && (pulse_len == '0) |=> !q);

  // R6: clear forces q low
  p_clear_low_r6: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> !q);

  // R10: no pulse starts by itself
  p_no_self_start_r10: assert property (@(posedge clk) disable iff (rst)
    !q && !fire |=> !q);

endmodule

// File: tb/sim_osh_pulse_gen.sv
`timescale 1ns/1ps
module sim_osh_pulse_gen;

  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          f1 = 1'b1, f2 = 1'b1, r1 = 1'b1, r2 = 1'b1, cl = 1'b1;
  logic [LW-1:0] len = '0;
  logic          q, q_n;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    hi    = 0;
  string tag   = "R10";

  // reference model state
  int m_rem  = 0;
  bit m_prev = 1'b0;

  always #4 clk = ~clk;

  osh_pulse_gen #(.LEN_W(LW)) u0 (
    .clk(clk), .rst(rst), .fall1_n(f1), .fall2_n(f2), .rise1(r1), .rise2(r2),
    .clr_n(cl), .pulse_len(len), .q(q), .q_n(q_n)
  );

  function automatic bit rule(bit c, bit b1, bit b2, bit a1, bit a2);
    return c && b1 && b2 && (!a1 || !a2);
  endfunction

  always @(posedge clk) begin
    bit now;
    now = rule(cl, r1, r2, f1, f2);
    if (rst) m_rem = 0;
    else if (!cl) m_rem = 0;
    else if (now && !m_prev) m_rem = int'(len);
    else if (m_rem > 0) m_rem = m_rem - 1;
    m_prev = now;
  end

  always @(negedge clk) begin
    if (!rst) begin
      n_cmp++;
      if (q !== (m_rem > 0) || q_n !== !(m_rem > 0)) begin
        n_bad++;
        $display("FAIL %s R4 cycle compare: q=%b q_n=%b expected q=%b", tag, q, q_n, m_rem > 0);
      end
      if (q === 1'b1) hi++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_pins();
    f1 = 1; f2 = 1; r1 = 1; r2 = 1; cl = 1;
  endtask

  task automatic start(input string t);
    tag = t;
    tick(1);
    hi = 0;
  endtask

  initial begin
    tick(3);
    rst = 0;
    tick(1);
    chk(q == 0 && q_n == 1, "R10 reset state", int'(q), 0);

    // R1: falling pin 1, length 4
    start("R1"); len = 4; f1 = 0; tick(1); f1 = 1; tick(10);
    chk(hi == 4, "R1 fall1 pulse width", hi, 4);
    start("R1"); len = 3; f2 = 0; tick(1); f2 = 1; tick(10);
    chk(hi == 3, "R1 fall2 pulse width", hi, 3);

    // R2: rising pin with falling pin held low
    start("R2"); len = 3; f1 = 0; r1 = 0; tick(2); r1 = 1; tick(1);
    idle_pins(); tick(10);
    chk(hi == 3, "R2 rise1 pulse width", hi, 3);
    start("R2"); len = 2; f2 = 0; r2 = 0; tick(2); r2 = 1; tick(1);
    idle_pins(); tick(10);
    chk(hi == 2, "R2 rise2 pulse width", hi, 2);

    // R3: length sampled at trigger only; long length
    start("R3"); len = 4; f1 = 0; tick(1); f1 = 1; len = 20; tick(30);
    chk(hi == 4, "R3 length sampled at trigger", hi, 4);
    start("R3"); len = 255; f1 = 0; tick(1); f1 = 1; tick(265);
    chk(hi == 255, "R3 max length", hi, 255);

    // R5: retrigger at cycle 4 with length 6 -> 3 + 6
    start("R5"); len = 6; f1 = 0; tick(1); f1 = 1; tick(2);
    f1 = 0; tick(1); f1 = 1; tick(15);
    chk(hi == 9, "R5 retrigger extends", hi, 9);

    // R11: second falling pin while first low: no restart
    start("R11"); len = 5; f1 = 0; tick(1); f2 = 0; tick(2); idle_pins(); tick(10);
    chk(hi == 5, "R11 no restart without rule edge", hi, 5);

    // R6 / R7: clear cuts the pulse, then blocks triggers
    start("R6"); len = 10; f1 = 0; tick(1); f1 = 1; tick(2); cl = 0; tick(3);
    chk(hi == 3, "R6 clear ends pulse", hi, 3);
    tag = "R7"; f1 = 0; tick(1); f1 = 1; tick(1); r1 = 0; f2 = 0; tick(1); r1 = 1; tick(3);
    f2 = 1; tick(1); cl = 1; tick(6);
    chk(hi == 3, "R7 triggers ignored under clear, plain release idle", hi, 3);

    // R8: clear release with rule otherwise met
    start("R8"); len = 4; cl = 0; f1 = 0; tick(2); cl = 1; tick(1); idle_pins(); tick(10);
    chk(hi == 4, "R8 clear release triggers", hi, 4);

    // R9: zero length, and zero-length retrigger ends pulse
    start("R9"); len = 0; f1 = 0; tick(1); f1 = 1; tick(5);
    chk(hi == 0, "R9 zero length no pulse", hi, 0);
    start("R9"); len = 8; f1 = 0; tick(1); f1 = 1; len = 0; tick(1);
    f1 = 0; tick(1); f1 = 1; tick(10);
    chk(hi == 2, "R9 zero-length retrigger ends pulse", hi, 2);

    // R10: reset mid-pulse
    start("R10"); len = 50; f1 = 0; tick(1); f1 = 1; tick(3); rst = 1; tick(1);
    rst = 0; tick(1);
    chk(q == 0 && q_n == 1, "R10 reset ends pulse", int'(q), 0);

    // mixed random phase, model compared every cycle
    tag = "R3 random";
    for (int i = 0; i < 4000; i++) begin
      f1  = 1'($urandom_range(0, 1));
      f2  = 1'($urandom_range(0, 1));
      r1  = ($urandom_range(0, 3) != 0);
      r2  = ($urandom_range(0, 3) != 0);
      cl  = ($urandom_range(0, 15) != 0);
      len = LW'($urandom_range(0, 12));
      tick(1);
    end
    idle_pins(); tick(20);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule